// File: doc/BRIEF.md
# Instruction Format Decoder

This block takes the first 16-bit word of an instruction in a three-format, variable-length instruction set and decodes it in a single combinational pass. The two most significant bits select one of three field layouts: register-register, register-immediate or conditional branch. For the selected layout the block extracts the opcode, the register indices and the short immediate.

The block also reports how many bytes the whole instruction occupies: 2, 4 or 6. Fetch logic uses this value to decide how many extension words to collect before it issues the instruction. A coarse class code lets the issue stage steer the instruction without decoding the opcode again. An illegal flag marks encodings that have no defined meaning.

The block has no clock and no state. Every output is a pure function of the input word. Fetching the extension words and executing the instruction are handled elsewhere.

Top module: `instr_fmt_decoder`

## Requirements
- R1: When bit 15 is 0, `fmt` is 1. `opcode` is bits 15:8, `reg_a` is bits 7:4, `reg_b` is bits 3:0 and `imm8` is 0. These fields are extracted even when the opcode is illegal.
- R2: When bits 15:14 are 10, `fmt` is 2. `opcode` is bits 13:12, zero-extended. `reg_a` is bits 11:8, `reg_b` is 0 and `imm8` is bits 7:0. All four opcodes (add immediate, subtract immediate, read special register, write special register) are legal, have class ALU (1) and are 2 bytes long.
- R3: When bits 15:14 are 11, `fmt` is 3. `opcode` is bits 13:10, zero-extended, and `reg_a`, `reg_b` and `imm8` are 0. Opcodes 0 to 9 are legal, have class BRANCH (4) and are 2 bytes long. Opcodes 10 to 15 are illegal.
- R4: The format-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24 and 0x30 give `len_bytes` = 6.
- R5: The format-1 opcodes 0x0C, 0x0D and 0x36 to 0x39 give `len_bytes` = 4.
- R6: Every other legal word gives `len_bytes` = 2. `len_bytes` never takes a value other than 2, 4 or 6.
- R7: The format-1 opcodes 0x00, 0x16, 0x17, 0x18 and 0x3A to 0xFF are illegal.
- R8: An illegal word gives `illegal` = 1, `len_bytes` = 2 and `iclass` = ILLEGAL (9). `illegal` is 1 exactly when `iclass` is 9.
- R9: The control-flow classes in format 1 are:
  - NOP (0) for opcode 0x0F;
  - CALL (5) for 0x03 and 0x19;
  - RETURN (6) for 0x04;
  - JUMP (7) for 0x1A and 0x25;
  - TRAP (8) for 0x30 and 0x35.
- R10: The memory classes in format 1 are:
  - LOAD (2) for 0x07, 0x08, 0x0A, 0x0C, 0x1C, 0x1D, 0x21, 0x22, 0x36 and 0x38;
  - STORE (3) for 0x06, 0x09, 0x0B, 0x0D, 0x1E, 0x1F, 0x23, 0x24, 0x37 and 0x39.
- R11: Every legal format-1 opcode not named in R9 or R10 has class ALU (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 16 | First word of the instruction |
| fmt | output | 2 | Layout selected: 1, 2 or 3 |
| opcode | output | 8 | Opcode, zero-extended for formats 2 and 3 |
| reg_a | output | 4 | First register index |
| reg_b | output | 4 | Second register index (format 1 only) |
| imm8 | output | 8 | Short unsigned immediate (format 2 only) |
| len_bytes | output | 3 | Total instruction length in bytes |
| illegal | output | 1 | Encoding is undefined |
| iclass | output | 4 | Class code, as listed in R2, R3 and R8 to R11 |

## Verification
The block holds no state, so any decoding fault shows on the ports in the same cycle as the word that triggers it. It cannot be hidden or delayed by later inputs. A wrong length or class entry affects only the few opcodes it belongs to. For that reason the bench applies all 65536 words, one per clock, and compares every output against a table built independently from the requirements. A fault confined to a single opcode value is therefore reported for each of the 256 words that share that opcode.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int IW_W  = 16;
    localparam int OPC_W = 8;
    localparam int REG_W = 4;
    localparam int IMM_W = 8;
    localparam int LEN_W = 3;
    localparam int F2_OPC_W = 2;
    localparam int F3_OPC_W = 4;

    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_MID   = LEN_W'(4);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(6);

    localparam logic [F3_OPC_W-1:0] F3_LAST_COND = F3_OPC_W'(9);

    typedef enum logic [1:0] {
        FMT_NONE  = 2'd0,
        FMT_ONE   = 2'd1,
        FMT_TWO   = 2'd2,
        FMT_THREE = 2'd3
    } fmt_e;

    typedef enum logic [3:0] {
        CL_NOP     = 4'd0,
        CL_ALU     = 4'd1,
        CL_LOAD    = 4'd2,
        CL_STORE   = 4'd3,
        CL_BRANCH  = 4'd4,
        CL_CALL    = 4'd5,
        CL_RETURN  = 4'd6,
        CL_JUMP    = 4'd7,
        CL_TRAP    = 4'd8,
        CL_ILLEGAL = 4'd9
    } iclass_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [REG_W-1:0] reg_a;
        logic [REG_W-1:0] reg_b;
        logic [IMM_W-1:0] imm;
        logic [LEN_W-1:0] len;
        logic             illegal;
        iclass_e          iclass;
    } dec_t;

endpackage

// File: rtl/ifd_f1_decode.sv
module ifd_f1_decode
    import ifd_pkg::*;
(
    input  logic [IW_W-1:0] word_i,
    output dec_t            dec_o
);

    logic [OPC_W-1:0] opc;
    iclass_e          cls;
    logic [LEN_W-1:0] ext_len;

    assign opc = word_i[IW_W-1 -: OPC_W];

    // class lookup; anything not listed has no defined meaning
    always_comb begin
        unique case (opc) inside
            8'h0f:
                cls = CL_NOP;
            8'h01, 8'h02, 8'h05, 8'h0e, [8'h10:8'h15], 8'h1b, 8'h20,
            [8'h26:8'h2f], [8'h31:8'h34]:
                cls = CL_ALU;
            8'h07, 8'h08, 8'h0a, 8'h0c, 8'h1c, 8'h1d, 8'h21, 8'h22,
            8'h36, 8'h38:
                cls = CL_LOAD;
            8'h06, 8'h09, 8'h0b, 8'h0d, 8'h1e, 8'h1f, 8'h23, 8'h24,
            8'h37, 8'h39:
                cls = CL_STORE;
            8'h03, 8'h19:
                cls = CL_CALL;
            8'h04:
                cls = CL_RETURN;
            8'h1a, 8'h25:
                cls = CL_JUMP;
            8'h30, 8'h35:
                cls = CL_TRAP;
            default:
                cls = CL_ILLEGAL;
        endcase
    end

    // length from the extension each opcode carries
    always_comb begin
        unique case (opc) inside
            8'h01, 8'h03, 8'h08, 8'h09, 8'h1a, 8'h1b, 8'h1d, 8'h1f,
            8'h20, 8'h22, 8'h24, 8'h30:
                ext_len = LEN_LONG;
            8'h0c, 8'h0d, [8'h36:8'h39]:
                ext_len = LEN_MID;
            default:
                ext_len = LEN_SHORT;
        endcase
    end

    always_comb begin
        dec_o.opcode  = opc;
        dec_o.reg_a   = word_i[7:4];
        dec_o.reg_b   = word_i[3:0];
        dec_o.imm     = '0;
        dec_o.illegal = (cls == CL_ILLEGAL);
        dec_o.iclass  = cls;
        dec_o.len     = (cls == CL_ILLEGAL) ? LEN_SHORT : ext_len;
    end

endmodule

// File: rtl/ifd_f2_decode.sv
module ifd_f2_decode
    import ifd_pkg::*;
(
    input  logic [IW_W-1:0] word_i,
    output dec_t            dec_o
);

    logic [F2_OPC_W-1:0] sub_op;

    assign sub_op = word_i[13:12];

    always_comb begin
        dec_o.opcode  = OPC_W'(sub_op);
        dec_o.reg_a   = word_i[11:8];
        dec_o.reg_b   = '0;
        dec_o.imm     = word_i[IMM_W-1:0];
        dec_o.len     = LEN_SHORT;
        dec_o.illegal = 1'b0;
        dec_o.iclass  = CL_ALU;
    end

endmodule

// File: rtl/ifd_f3_decode.sv
module ifd_f3_decode
    import ifd_pkg::*;
(
    input  logic [IW_W-1:0] word_i,
    output dec_t            dec_o
);

    logic [F3_OPC_W-1:0] cond;
    logic                bad;

    assign cond = word_i[13:10];
    assign bad  = (cond > F3_LAST_COND);

    always_comb begin
        dec_o.opcode  = OPC_W'(cond);
        dec_o.reg_a   = '0;
        dec_o.reg_b   = '0;
        dec_o.imm     = '0;
        dec_o.len     = LEN_SHORT;
        dec_o.illegal = bad;
        dec_o.iclass  = bad ? CL_ILLEGAL : CL_BRANCH;
    end

endmodule

// File: rtl/instr_fmt_decoder.sv
module instr_fmt_decoder
    import ifd_pkg::*;
(
    input  logic [15:0] instr_word,
    output logic [1:0]  fmt,
    output logic [7:0]  opcode,
    output logic [3:0]  reg_a,
    output logic [3:0]  reg_b,
    output logic [7:0]  imm8,
    output logic [2:0]  len_bytes,
    output logic        illegal,
    output logic [3:0]  iclass
);

    fmt_e sel_fmt;
    dec_t dec_f1, dec_f2, dec_f3, dec_sel;

    always_comb begin
        unique case (instr_word[15:14])
            2'b00, 2'b01: sel_fmt = FMT_ONE;
            2'b10:        sel_fmt = FMT_TWO;
            default:      sel_fmt = FMT_THREE;
        endcase
    end

    ifd_f1_decode i_f1 (.word_i(instr_word), .dec_o(dec_f1));
    ifd_f2_decode i_f2 (.word_i(instr_word), .dec_o(dec_f2));
    ifd_f3_decode i_f3 (.word_i(instr_word), .dec_o(dec_f3));

    always_comb begin
        unique case (sel_fmt)
            FMT_ONE: dec_sel = dec_f1;
            FMT_TWO: dec_sel = dec_f2;
            default: dec_sel = dec_f3;
        endcase
    end

    assign fmt       = sel_fmt;
    assign opcode    = dec_sel.opcode;
    assign reg_a     = dec_sel.reg_a;
    assign reg_b     = dec_sel.reg_b;
    assign imm8      = dec_sel.imm;
    assign len_bytes = dec_sel.len;
    assign illegal   = dec_sel.illegal;
    assign iclass    = dec_sel.iclass;

endmodule

// File: rtl/instr_fmt_decoder_chk.sv
module instr_fmt_decoder_chk (
    input logic [15:0] instr_word,
    input logic [1:0]  fmt,
    input logic [7:0]  opcode,
    input logic [3:0]  reg_a,
    input logic [3:0]  reg_b,
    input logic [7:0]  imm8,
    input logic [2:0]  len_bytes,
    input logic        illegal,
    input logic [3:0]  iclass
);

    always_comb begin
        if (!$isunknown(instr_word)) begin
            a_r1_fmt_follows_top_bit: assert ((fmt == 2'd1) == (instr_word[15] == 1'b0))
                else $error("R1 format select");
            a_r2_no_second_reg: assert (fmt != 2'd2 || (reg_b == 4'd0 && iclass == 4'd1))
                else $error("R2 register-immediate layout");
            a_r3_branch_short: assert (fmt != 2'd3 || (len_bytes == 3'd2 && imm8 == 8'd0))
                else $error("R3 branch layout");
            a_r6_len_legal_values: assert (len_bytes == 3'd2 || len_bytes == 3'd4 || len_bytes == 3'd6)
                else $error("R6 length value");
            a_r8_illegal_short: assert (!illegal || len_bytes == 3'd2)
                else $error("R8 illegal length");
            a_r8_flag_matches_class: assert (illegal == (iclass == 4'd9))
                else $error("R8 illegal flag vs class");
            a_r1_opcode_passthrough: assert (fmt != 2'd1 || opcode == instr_word[15:8])
                else $error("R1 opcode field");
        end
    end

endmodule

bind instr_fmt_decoder instr_fmt_decoder_chk i_chk (
    .instr_word(instr_word),
    .fmt(fmt),
    .opcode(opcode),
    .reg_a(reg_a),
    .reg_b(reg_b),
    .imm8(imm8),
    .len_bytes(len_bytes),
    .illegal(illegal),
    .iclass(iclass)
);

// File: tb/test_instr_fmt_decoder.sv
`timescale 1ns/1ps
module test_instr_fmt_decoder;

    logic        clk = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic [1:0]  fmt;
    logic [7:0]  opcode;
    logic [3:0]  reg_a, reg_b;
    logic [7:0]  imm8;
    logic [2:0]  len_bytes;
    logic        illegal;
    logic [3:0]  iclass;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int f1_len [256];
    int f1_cls [256];

    always #4 clk = ~clk;

    instr_fmt_decoder i_instr_fmt_decoder (
        .instr_word(instr_word), .fmt(fmt), .opcode(opcode),
        .reg_a(reg_a), .reg_b(reg_b), .imm8(imm8),
        .len_bytes(len_bytes), .illegal(illegal), .iclass(iclass)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s word=%h actual=%0d expected=%0d", tag, what, instr_word, act, exp);
        end
    endtask

    task automatic put(input int q[$], input int len, input int cls);
        foreach (q[k]) begin
            if (len != 0) f1_len[q[k]] = len;
            if (cls >= 0) f1_cls[q[k]] = cls;
        end
    endtask

    task automatic build_tables();
        for (int op = 0; op < 256; op++) begin
            f1_len[op] = 2;
            f1_cls[op] = (op == 0 || (op >= 'h16 && op <= 'h18) || op > 'h39) ? 9 : 1; // R7 R11
        end
        put('{'h01, 'h03, 'h08, 'h09, 'h1a, 'h1b, 'h1d, 'h1f, 'h20, 'h22, 'h24, 'h30}, 6, -1); // R4
        put('{'h0c, 'h0d, 'h36, 'h37, 'h38, 'h39}, 4, -1);                                     // R5
        put('{'h0f}, 0, 0);                                                                    // R9
        put('{'h03, 'h19}, 0, 5);
        put('{'h04}, 0, 6);
        put('{'h1a, 'h25}, 0, 7);
        put('{'h30, 'h35}, 0, 8);
        put('{'h07, 'h08, 'h0a, 'h0c, 'h1c, 'h1d, 'h21, 'h22, 'h36, 'h38}, 0, 2);              // R10
        put('{'h06, 'h09, 'h0b, 'h0d, 'h1e, 'h1f, 'h23, 'h24, 'h37, 'h39}, 0, 3);
    endtask

    task automatic compare(input int w);
        int ef, eo, ea, eb, ei, el, ec;
        string ftag, ltag, ctag;
        if (w < 'h8000) begin
            ef = 1; eo = w >> 8; ea = (w >> 4) & 15; eb = w & 15; ei = 0;
            ec = f1_cls[eo]; el = f1_len[eo]; ftag = "R1";
            ctag = (ec == 9) ? "R7" : (ec == 1) ? "R11" : (ec == 2 || ec == 3) ? "R10" : "R9";
        end else if (w < 'hC000) begin
            ef = 2; eo = (w >> 12) & 3; ea = (w >> 8) & 15; eb = 0; ei = w & 255;
            ec = 1; el = 2; ftag = "R2"; ctag = "R2";
        end else begin
            ef = 3; eo = (w >> 10) & 15; ea = 0; eb = 0; ei = 0;
            ec = (eo > 9) ? 9 : 4; el = 2; ftag = "R3"; ctag = "R3";
        end
        if (ec == 9) begin
            el = 2; ltag = "R8";
        end else begin
            ltag = (el == 6) ? "R4" : (el == 4) ? "R5" : "R6";
        end
        chk(ftag, "fmt", int'(fmt), ef);
        chk(ftag, "opcode", int'(opcode), eo);
        chk(ftag, "reg_a", int'(reg_a), ea);
        chk(ftag, "reg_b", int'(reg_b), eb);
        chk(ftag, "imm8", int'(imm8), ei);
        chk(ltag, "len_bytes", int'(len_bytes), el);
        chk(ctag, "iclass", int'(iclass), ec);
        chk("R8", "illegal", int'(illegal), (ec == 9) ? 1 : 0);
    endtask

    initial begin
        build_tables();
        // word 0 at start: illegal format-1 opcode 0 (R7, R8)
        @(negedge clk);
        chk("R8", "start illegal", int'(illegal), 1);
        chk("R8", "start len", int'(len_bytes), 2);
        chk("R7", "start class", int'(iclass), 9);
        // spot checks
        @(posedge clk); instr_word <= 16'h0F5A;
        @(negedge clk);
        chk("R9", "nop class", int'(iclass), 0);
        chk("R1", "nop reg_b", int'(reg_b), 10);
        @(posedge clk); instr_word <= 16'h3512;
        @(negedge clk);
        chk("R9", "breakpoint class", int'(iclass), 8);
        @(posedge clk); instr_word <= 16'hA7C3;
        @(negedge clk);
        chk("R2", "imm", int'(imm8), 'hC3);
        chk("R2", "reg", int'(reg_a), 7);
        @(posedge clk); instr_word <= 16'hE800;
        @(negedge clk);
        chk("R3", "cond 10 illegal", int'(illegal), 1);
        // exhaustive sweep
        for (int w = 0; w < 65536; w++) begin
            @(posedge clk);
            instr_word <= 16'(w);
            @(negedge clk);
            compare(w);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule